// File: doc/BRIEF.md
# Slotted Anti-Collision Inventory Sequencer

This block runs a complete sixteen-slot inventory of contactless tags after a single trigger from the host. It first emits an inventory call that opens sixteen time slots, then fifteen slot-marker commands numbered 1 to 15 in rising order. After each command it waits for one tag reply carrying an 8-bit chip identifier. The wait ends when a reply arrives or when a parameterised timeout expires, whichever comes first. The block then moves on to the next command without any help from the host.

Each slot's outcome goes into a small result frame that the host reads through a plain address/data port. A reply whose receiver CRC flag is good sets the slot's status bit and stores its identifier. A missing reply, or a reply with a failed CRC, clears the status bit and leaves the identifier at 00h. `busy` is high for the whole run. `done` rises once slot 15 has been resolved.

Commands leave on a valid/ready stream. `cmd_valid` stays high, with opcode and slot number unchanged, until the transmitter takes the command by raising `cmd_ready`. Replies arrive on a second valid/ready stream. `rep_ready` is high only while a slot is waiting, so a reply offered at any other time is neither accepted nor recorded.

Top module: `slot_anticoll_seq`

## Requirements
- R1: A one-cycle `go` pulse while idle starts a run, and `busy` is high from the next cycle until the run ends. A `go` pulse while `busy` is high has no effect on the run.
- R2: Commands are issued in a fixed order. First comes opcode `OPC_CALL` with slot number 0, then opcode `OPC_MARK` with slot numbers 1 through 15 in ascending order, with exactly one command per slot.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_opcode` and `cmd_slot` hold their values. A command is taken on the cycle where both `cmd_valid` and `cmd_ready` are high.
- R4: `rep_ready` is high only in the wait that follows an accepted command. A reply is taken when `rep_valid` and `rep_ready` are both high, and that ends the slot. A reply offered while `rep_ready` is low is not recorded.
- R5: If no reply is taken, the slot ends after `rep_ready` has been high for exactly `TIMEOUT` cycles, and it is recorded as empty.
- R6: A taken reply with `rep_crc_ok` = 1 sets status bit n of slot n and stores `rep_id` at frame byte 3+n.
- R7: A taken reply with `rep_crc_ok` = 0, or a timed-out slot, clears status bit n and leaves frame byte 3+n at 00h.
- R8: The frame layout is: byte 0 reads 18 (the number of result bytes that follow), byte 1 holds status bits 0–7 (bit n = slot n), byte 2 holds status bits 8–15, bytes 3–18 hold the identifiers of slots 0–15, and any other address reads 00h.
- R9: The cycle after slot 15 is resolved, `done` is 1 and `busy` is 0. `done` stays high until the next accepted `go`, and `done` and `busy` are never high together.
- R10: An accepted `go` clears all status bits and identifiers, so no result from an earlier run survives into the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse for a full inventory run |
| cmd_valid | output | 1 | Command available on the command stream |
| cmd_ready | input | 1 | Transmitter takes the command |
| cmd_opcode | output | 8 | Command opcode (call or slot marker) |
| cmd_slot | output | 4 | Slot number carried by the command |
| rep_valid | input | 1 | Reply available from the receiver |
| rep_ready | output | 1 | Block is waiting for a reply |
| rep_id | input | 8 | Chip identifier in the reply |
| rep_crc_ok | input | 1 | Receiver found the reply CRC correct |
| rd_addr | input | 5 | Result frame byte address |
| rd_data | output | 8 | Result frame byte at `rd_addr` |
| busy | output | 1 | Inventory run in progress |
| done | output | 1 | Last run completed |

## Verification
The embedded properties watch, on every cycle, that a stalled command holds steady, that the slot number climbs by one after each resolved slot, that the reply stream is ready only during a wait, and that the wait counter never passes the timeout. They also watch that `done` and `busy` exclude each other, that `done` rises only after slot 15, and that a start or a failed slot leaves the relevant status bits at zero. Only the bench scenarios can show the full opcode sequence, the exact length of a timed-out wait, the mapping of slots to frame bytes, the fact that stray replies and mid-run starts are ignored, and the clearing of an earlier run's results.

// File: rtl/anticoll_pkg.sv
package anticoll_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEND = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/anticoll_wait_timer.sv
module anticoll_wait_timer #(
  parameter int TIMEOUT = 32,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (!expired)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CNT_W'(TIMEOUT - 1));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CNT_W'(TIMEOUT)));
endmodule

// File: rtl/anticoll_seq_ctrl.sv
module anticoll_seq_ctrl
  import anticoll_pkg::*;
#(
  parameter int         N_SLOTS  = 16,
  parameter logic [7:0] OPC_CALL = 8'h06,
  parameter logic [7:0] OPC_MARK = 8'h04,
  localparam int        SLOT_W   = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cmd_ready,
  input  logic              rep_valid,
  input  logic              rep_crc_ok,
  input  logic              tmo,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic [SLOT_W-1:0] cmd_slot,
  output logic              rep_ready,
  output logic              busy,
  output logic              done,
  output logic              clr,
  output logic              res_we,
  output logic              res_ok,
  output logic [SLOT_W-1:0] res_slot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  seq_state_t        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q;
  logic              took_rep;

  assign took_rep   = (state_q == SQ_WAIT) && rep_valid;
  assign res_we     = (state_q == SQ_WAIT) && (rep_valid || tmo);
  assign res_ok     = took_rep && rep_crc_ok;
  assign res_slot   = slot_q;
  assign clr        = (state_q == SQ_IDLE) && go;
  assign cmd_valid  = (state_q == SQ_SEND);
  assign cmd_slot   = slot_q;
  assign cmd_opcode = (slot_q == '0) ? OPC_CALL : OPC_MARK;
  assign rep_ready  = (state_q == SQ_WAIT);
  assign busy       = (state_q != SQ_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (go) begin
          state_q <= SQ_SEND;
          slot_q  <= '0;
          done_q  <= 1'b0;
        end
        SQ_SEND: if (cmd_ready) state_q <= SQ_WAIT;
        SQ_WAIT: if (res_we) begin
          if (slot_q == LAST_SLOT) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= SQ_SEND;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_slot) && $stable(cmd_opcode)));
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (res_slot != LAST_SLOT)) |=> (cmd_valid && (cmd_slot == $past(res_slot) + 1'b1)));
  p_rep_only_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ready |-> (busy && !cmd_valid));
  p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (res_slot == LAST_SLOT)) |=> (done && !busy));
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && cmd_valid && (cmd_slot == '0)));
endmodule

// File: rtl/anticoll_result_store.sv
module anticoll_result_store #(
  parameter int  N_SLOTS    = 16,
  parameter int  BYTE_W     = 8,
  localparam int SLOT_W     = $clog2(N_SLOTS),
  localparam int MASK_BYTES = N_SLOTS / BYTE_W,
  localparam int ID_BASE    = 1 + MASK_BYTES,
  localparam int FRAME_LEN  = MASK_BYTES + N_SLOTS,
  localparam int ADDR_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic              ok,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] id,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [N_SLOTS-1:0] mask_q;
  logic [BYTE_W-1:0]  ids_q [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        mask_q[s] <= 1'b0;
        ids_q[s]  <= '0;
      end else if (we && (slot == SLOT_W'(s))) begin
        mask_q[s] <= ok;
        ids_q[s]  <= ok ? id : '0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = BYTE_W'(FRAME_LEN);
    for (int b = 0; b < MASK_BYTES; b++)
      if (rd_addr == ADDR_W'(1 + b)) rd_data = mask_q[b*BYTE_W +: BYTE_W];
    for (int s = 0; s < N_SLOTS; s++)
      if (rd_addr == ADDR_W'(ID_BASE + s)) rd_data = ids_q[s];
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask_q == '0));
  p_fail_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ok && !clr) |=> (mask_q[$past(slot)] == 1'b0));
  p_ok_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ok && !clr) |=> (mask_q[$past(slot)] == 1'b1));
endmodule

// File: rtl/slot_anticoll_seq.sv
module slot_anticoll_seq #(
  parameter int         TIMEOUT  = 32,
  parameter logic [7:0] OPC_CALL = 8'h06,
  parameter logic [7:0] OPC_MARK = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_opcode,
  output logic [3:0] cmd_slot,
  input  logic       rep_valid,
  output logic       rep_ready,
  input  logic [7:0] rep_id,
  input  logic       rep_crc_ok,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done
);
  localparam int N_SLOTS = 16;
  localparam int BYTE_W  = 8;

  logic       tmo;
  logic       clr;
  logic       res_we;
  logic       res_ok;
  logic [3:0] res_slot;

  anticoll_seq_ctrl #(
    .N_SLOTS (N_SLOTS),
    .OPC_CALL(OPC_CALL),
    .OPC_MARK(OPC_MARK)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cmd_ready (cmd_ready),
    .rep_valid (rep_valid),
    .rep_crc_ok(rep_crc_ok),
    .tmo       (tmo),
    .cmd_valid (cmd_valid),
    .cmd_opcode(cmd_opcode),
    .cmd_slot  (cmd_slot),
    .rep_ready (rep_ready),
    .busy      (busy),
    .done      (done),
    .clr       (clr),
    .res_we    (res_we),
    .res_ok    (res_ok),
    .res_slot  (res_slot)
  );

  anticoll_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (rep_ready),
    .expired(tmo)
  );

  anticoll_result_store #(.N_SLOTS(N_SLOTS), .BYTE_W(BYTE_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .we     (res_we),
    .ok     (res_ok),
    .slot   (res_slot),
    .id     (rep_id),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );
endmodule

// File: tb/test_slot_anticoll_seq.sv
module test_slot_anticoll_seq;
  localparam int TMO = 32;
  localparam logic [7:0] OP_C = 8'h06;
  localparam logic [7:0] OP_M = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [7:0] cmd_opcode;
  logic [3:0] cmd_slot;
  logic rep_valid = 1'b0, rep_ready, rep_crc_ok = 1'b0;
  logic [7:0] rep_id = 8'h00;
  logic [4:0] rd_addr = 5'd0;
  logic [7:0] rd_data;
  logic busy, done;

  int checks = 0, failures = 0, cycles = 0;
  int mode [16];   // 0 none, 1 good reply, 2 CRC-bad reply
  logic [7:0] ids [16];
  int stall [16];

  always #10 clk = ~clk;

  slot_anticoll_seq #(.TIMEOUT(TMO), .OPC_CALL(OP_C), .OPC_MARK(OP_M)) i_slot_anticoll_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_slot(cmd_slot), .rep_valid(rep_valid),
    .rep_ready(rep_ready), .rep_id(rep_id), .rep_crc_ok(rep_crc_ok),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      finish_run();
    end
  end

  task automatic rd(input int a, output logic [7:0] d);
    rd_addr = 5'(a);
    #1 d = rd_data;
  endtask

  task automatic check_frame();
    logic [7:0] d;
    logic [15:0] m;
    m = '0;
    for (int s = 0; s < 16; s++) m[s] = (mode[s] == 1);
    rd(0, d);  chk(d == 8'd18, "R8 len byte", d, 18);
    rd(1, d);  chk(d == m[7:0], "R8 mask low", d, m[7:0]);
    rd(2, d);  chk(d == m[15:8], "R8 mask high", d, m[15:8]);
    for (int s = 0; s < 16; s++) begin
      rd(3 + s, d);
      if (mode[s] == 1) chk(d == ids[s], "R6 id stored", d, ids[s]);
      else chk(d == 8'h00, "R7 id empty", d, 0);
    end
    rd(25, d); chk(d == 8'h00, "R8 out of range", d, 0);
  endtask

  // full run; optional stray reply and mid-run go at slot 2
  task automatic run_seq(input bit disturb);
    int n;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    chk(busy && !done, "R1 busy after go", {busy, done}, 2);
    for (int s = 0; s < 16; s++) begin
      n = 0;
      while (!cmd_valid && n < 200) begin @(negedge clk); n++; end
      chk(cmd_valid && cmd_slot == 4'(s), "R2 slot order", cmd_slot, s);
      chk(cmd_opcode == (s == 0 ? OP_C : OP_M), "R2 opcode", cmd_opcode, s == 0 ? OP_C : OP_M);
      for (int k = 0; k < stall[s]; k++) begin
        if (disturb && s == 2 && k == 0) begin
          rep_valid = 1'b1; rep_id = 8'hEE; rep_crc_ok = 1'b1; go = 1'b1;
        end
        @(negedge clk);
        rep_valid = 1'b0; go = 1'b0;
        chk(cmd_valid && cmd_slot == 4'(s), "R3 hold under stall", cmd_slot, s);
      end
      if (disturb && s == 2) chk(!rep_ready, "R4 no ready in send", rep_ready, 0);
      cmd_ready = 1'b1;
      @(negedge clk) cmd_ready = 1'b0;
      chk(rep_ready && !cmd_valid, "R4 ready after cmd", rep_ready, 1);
      if (mode[s] == 0) begin
        n = 0;
        while (rep_ready && n < 200) begin @(negedge clk); n++; end
        chk(n == TMO, "R5 timeout length", n, TMO);
      end else begin
        for (int k = 0; k < (s % 4); k++) @(negedge clk);
        rep_valid = 1'b1; rep_id = ids[s]; rep_crc_ok = (mode[s] == 1);
        @(negedge clk);
        rep_valid = 1'b0; rep_crc_ok = 1'b0;
        chk(!rep_ready, "R4 reply ends wait", rep_ready, 0);
      end
    end
    chk(done && !busy, "R9 done after slot 15", {done, busy}, 2);
    repeat (3) @(negedge clk);
    chk(done && !busy && !cmd_valid, "R9 done held", {done, busy}, 2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(!busy && !done && !cmd_valid && !rep_ready, "R1 reset idle",
        {busy, done, cmd_valid, rep_ready}, 0);
    rd(1, d); chk(d == 0, "R8 reset mask", d, 0);
    rd(0, d); chk(d == 8'd18, "R8 reset len", d, 18);
  endtask

  task automatic t_all_good();
    for (int s = 0; s < 16; s++) begin
      mode[s] = 1; ids[s] = 8'(8'h30 + s * 7); stall[s] = (s % 3);
    end
    run_seq(1'b0);
    check_frame();
  endtask

  task automatic t_mixed();
    for (int s = 0; s < 16; s++) begin
      mode[s] = (s % 3 == 0) ? 1 : (s % 3 == 1) ? 0 : 2;
      ids[s] = 8'(8'hA1 + s); stall[s] = (s == 2) ? 3 : 0;
    end
    mode[2] = 0;  // stray reply during send must not land here
    run_seq(1'b1);
    check_frame();
  endtask

  task automatic t_rerun_clear();
    logic [7:0] d;
    for (int s = 0; s < 16; s++) begin mode[s] = 0; ids[s] = 8'h55; stall[s] = 0; end
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    rd(1, d); chk(d == 0, "R10 mask low cleared", d, 0);
    rd(3, d); chk(d == 0, "R10 id cleared", d, 0);
    chk(!done, "R9 done drops on go", done, 0);
    // finish this run as all-empty
    for (int s = 0; s < 16; s++) begin
      while (!cmd_valid) @(negedge clk);
      cmd_ready = 1'b1;
      @(negedge clk) cmd_ready = 1'b0;
      while (rep_ready) @(negedge clk);
    end
    chk(done && !busy, "R9 empty run done", {done, busy}, 2);
    check_frame();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_good();
    t_mixed();
    t_rerun_clear();
    finish_run();
  end
endmodule